// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

The block sits in front of a bank of DMA channels. It routes a set of peripheral request lines to those channels. Each request line has its own small map register. The register's enable flag says whether the line is routed at all, and its channel field names the channel that receives it. Request lines come from other clock domains, so each one first passes through a two-flop synchroniser. The mapper then ORs together every enabled line that targets the same channel to form that channel's request level.

For each channel the block holds the latest request level and presents it as the channel's pending-request input. It also raises a one-cycle event when the level goes high (the request-asserted status) and another when the level goes low (the end-of-receive status). These events feed the channels' status logic.

The CPU programs the map registers over a simple 32-bit register port with a combinational read path. The registers are split across two address windows. One window holds the first 64 requests. The other holds the remaining requests.

Top module: `dreq_router`

## Requirements
- R1: A map register keeps write-data bit 7 as its enable flag and bits 4:0 as its channel number. Read-back returns those bits in the same positions, and every other bit reads as zero.
- R2: The map register for request n, with n from 0 to 63, sits at byte offset 0x100 + 4·n.
- R3: The map register for request n, with n from 64 to 74, sits at byte offset 0x1100 + 4·(n−64).
- R4: A write to any offset outside the two windows changes no map register, and a read from such an offset returns zero.
- R5: After reset every map register reads zero, and all channel levels and events are low.
- R6: A request line whose map register has the enable flag clear has no effect on any channel. Clearing the flag of an active line removes its contribution one cycle after the write.
- R7: A change on a request input shows on the channel level on the third rising clock edge after the input changes: two synchroniser stages and one level register.
- R8: When a channel's level goes from low to high, its request-asserted event is high for exactly that one cycle. The event is never high at any other time.
- R9: When a channel's level goes from high to low, its end-of-receive event is high for exactly that one cycle. The event is never high at any other time.
- R10: When several enabled lines target the same channel, the channel level is the OR of those lines. A second line rising, or one of two active lines falling, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Byte offset; reads are combinational from it |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| req_in | input | 75 | Peripheral request lines, asynchronous |
| chan_req | output | 32 | Latest request level per channel |
| chan_rise | output | 32 | One-cycle request-asserted event per channel |
| chan_fall | output | 32 | One-cycle end-of-receive event per channel |

## Verification
Two kinds of same-cycle collision are provoked. In the first, one input vector makes one channel's level rise while another channel's level falls. The scoreboard then expects a single item carrying both a rise bit and a fall bit, and it fails if they arrive in different cycles. In the second, a map register is rewritten while its request line is active. The old channel must report end-of-receive in the same cycle as the new channel reports request-asserted. Any event the scoreboard did not expect is a mismatch.

// File: rtl/dreq_router.sv
module dreq_router #(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 32,
  parameter int LO_CNT  = 64,
  parameter int LO_BASE = 'h100,
  parameter int HI_BASE = 'h1100,
  parameter int ADDR_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_REQ-1:0]  req_in,
  output logic [NUM_CH-1:0]   chan_req,
  output logic [NUM_CH-1:0]   chan_rise,
  output logic [NUM_CH-1:0]   chan_fall
);
  localparam int IDX_W = $clog2(NUM_REQ);
  localparam int HI_CNT = NUM_REQ - LO_CNT;
  localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] LO_SPAN = ADDR_W'(4 * LO_CNT);
  localparam logic [ADDR_W-1:0] HI_SPAN = ADDR_W'(4 * HI_CNT);

  logic [NUM_REQ-1:0] sync1, sync2, map_vld;
  logic [4:0]         map_ch [NUM_REQ];
  logic [NUM_CH-1:0]  merged;
  logic [ADDR_W-1:0]  lo_off, hi_off;
  logic               lo_hit, hi_hit, hit;
  logic [IDX_W-1:0]   idx;

  assign lo_off = reg_addr - LO_B;
  assign hi_off = reg_addr - HI_B;
  assign lo_hit = (reg_addr[1:0] == 2'b00) && (lo_off < LO_SPAN);
  assign hi_hit = (reg_addr[1:0] == 2'b00) && (hi_off < HI_SPAN);
  assign hit    = lo_hit || hi_hit;
  assign idx    = lo_hit ? IDX_W'(lo_off >> 2) : IDX_W'(LO_CNT) + IDX_W'(hi_off >> 2);

  assign reg_rdata = hit ? {24'b0, map_vld[idx], 2'b00, map_ch[idx]} : 32'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld <= '0;
      for (int r = 0; r < NUM_REQ; r++) map_ch[r] <= '0;
    end else if (reg_wr_en && hit) begin
      map_vld[idx] <= reg_wdata[7];
      map_ch[idx]  <= reg_wdata[4:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= req_in;
      sync2 <= sync1;
    end
  end

  always_comb begin : route
    logic [31:0] sel;
    merged = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      sel = 32'b1 << map_ch[r];
      merged = merged | (sel[NUM_CH-1:0] & {NUM_CH{sync2[r] & map_vld[r]}});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_req  <= '0;
      chan_rise <= '0;
      chan_fall <= '0;
    end else begin
      chan_req  <= merged;
      chan_rise <= merged & ~chan_req;
      chan_fall <= ~merged & chan_req;
    end
  end

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (map_vld == '0) |=> (chan_req == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_rise_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_req[c]) |-> chan_rise[c]);
    assert_rise_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rise[c] |-> (chan_req[c] && !$past(chan_req[c])));
    assert_fall_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_req[c]) |-> chan_fall[c]);
    assert_fall_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_fall[c] |-> (!chan_req[c] && $past(chan_req[c])));
  end
endmodule

// File: tb/test_dreq_router.sv
module test_dreq_router;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         reg_wr_en = 0;
  logic [15:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [74:0]  req_in = '0;
  logic [31:0]  chan_req, chan_rise, chan_fall;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] expq [$];

  always #5 clk = ~clk;

  dreq_router i_dreq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .chan_req(chan_req), .chan_rise(chan_rise), .chan_fall(chan_fall));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ((chan_rise | chan_fall) != 0)) begin
      n_cmp++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R8/R9 unexpected event: actual rise %h fall %h expected none",
                 chan_rise, chan_fall);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        if ({chan_rise, chan_fall} !== e) begin
          n_bad++;
          $display("FAIL R8/R9 event: actual rise %h fall %h expected rise %h fall %h",
                   chan_rise, chan_fall, e[63:32], e[31:0]);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata, exp, tag);
  endtask

  task automatic drive(input logic [74:0] nv, input logic [31:0] erise,
                       input logic [31:0] efall, input logic [31:0] elvl, input string tag);
    logic [31:0] old;
    @(negedge clk);
    old = chan_req;
    if ((erise | efall) != 0) expq.push_back({erise, efall});
    req_in = nv;
    @(negedge clk);
    @(negedge clk);
    chk(chan_req, old, {tag, " R7 level before third edge"});
    @(negedge clk);
    chk(chan_req, elvl, {tag, " R7 level after third edge"});
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(chan_req, 0, "R5 level after reset");
    chk(chan_rise | chan_fall, 0, "R5 events after reset");
    rd(16'h0100, 0, "R5 map 0 after reset");
    rd(16'h1128, 0, "R5 map 74 after reset");

    wr(16'h0100, 32'hFFFF_FF83);
    rd(16'h0100, 32'h83, "R1 R2 map 0 readback masked");
    wr(16'h01FC, 32'h85);
    rd(16'h01FC, 32'h85, "R2 map 63 readback");
    wr(16'h1100, 32'h83);
    rd(16'h1100, 32'h83, "R3 map 64 readback");
    wr(16'h1128, 32'h87);
    rd(16'h1128, 32'h87, "R3 map 74 readback");

    wr(16'h0200, 32'hFF);
    wr(16'h00FC, 32'h9F);
    wr(16'h112C, 32'h9F);
    rd(16'h0200, 0, "R4 read outside windows");
    rd(16'h112C, 0, "R4 read past high window");
    rd(16'h0100, 32'h83, "R4 map 0 untouched");
    rd(16'h1100, 32'h83, "R4 map 64 untouched");
    rd(16'h1128, 32'h87, "R4 map 74 untouched");

    wr(16'h0104, 32'h03);
    rd(16'h0104, 32'h03, "R1 disabled map readback");
    drive(75'h2, 0, 0, 0, "R6 disabled line ignored");
    drive(75'h0, 0, 0, 0, "R6 disabled line drop");

    drive(75'h1, 32'h8, 0, 32'h8, "R8 rise ch3");
    drive(75'h1 | (75'h1 << 64), 0, 0, 32'h8, "R10 second line no event");
    drive(75'h1 << 64, 0, 0, 32'h8, "R10 one of two falls");
    drive(75'h0, 0, 32'h8, 0, "R9 fall ch3");

    drive(75'h1 << 74, 32'h80, 0, 32'h80, "R8 rise ch7");
    drive(75'h1, 32'h8, 32'h80, 32'h8, "R8 R9 same cycle rise ch3 fall ch7");
    drive(75'h1 | (75'h1 << 63), 32'h20, 0, 32'h28, "R10 ch5 joins");
    drive(75'h1, 0, 32'h20, 32'h8, "R9 fall ch5");

    expq.push_back({32'h20, 32'h8});
    wr(16'h0100, 32'h85);
    repeat (2) @(negedge clk);
    chk(chan_req, 32'h20, "R8 R9 remap moves level");
    expq.push_back({32'h0, 32'h20});
    wr(16'h0100, 32'h05);
    repeat (2) @(negedge clk);
    chk(chan_req, 0, "R6 disable active line");

    repeat (4) @(negedge clk);
    chk(expq.size(), 0, "R8 R9 all expected events seen");
    finish_run();
  end
endmodule